// File: doc/BRIEF.md
# Unified Shader Workload Arbiter

This block sits in front of a sequencer that drives one shared pool of shader ALUs. In each issue slot it decides whether that pool takes a group of vertex work or a group of pixel work. It does not pick individual ALUs; the sequencer still does that. The block counts three queues itself, from push and pop pulses: pending vertex groups, pending pixel groups, and the downstream queue that rasterization fills with fragments. Vertex and pixel groups leave through a valid/ready issue port per type. A pop of a pending queue is the handshake on that port.

The policy compares the two pending occupancies and tries to keep them even. Pixel work goes first unless the vertex side is ahead. Software can write a signed bias that moves this balance point. Vertex work is held back while the downstream queue is full, because newly shaded vertices would have nowhere to put their fragments.

Two refinements keep the pool busy. First, if the preferred type is stalled, an eligible and ready other type takes the slot. Second, a bounded starvation counter makes sure waiting vertex work is served even under a strong pixel bias. Because of the slot-swap rule, each valid output depends combinationally on both ready inputs, so the sequencer's ready must not depend on this block's valid.

Top module: `unified_shader_arbiter`

## Requirements
- R1: After reset all three occupancies are zero, the bias is zero, the starvation count is zero and neither issue valid is asserted.
- R2: Only one issue valid is ever asserted in a cycle. When both types are eligible and the biased difference (vertex count − pixel count + bias) is zero or negative, pixel work is the preferred type; a tie favours pixels.
- R3: A type is eligible when its pending count is nonzero (vertex work also needs R4). When only one type is eligible, that type is offered; in particular, with no vertex work pending, every slot goes to pending pixel work.
- R4: Vertex valid is never asserted while the downstream queue holds DS_DEPTH entries. Its count rises on `ras_push_i` (ignored when full, unless popped in the same cycle) and falls on `ras_pop_i` (ignored when empty).
- R5: `bias_we_i` loads `bias_i` as a 4-bit two's-complement value, which takes effect from the next cycle. When both types are eligible, vertex work is preferred if vertex count − pixel count + bias > 0.
- R6: If the preferred type's ready is low while the other type is eligible with its ready high, the other type's valid is asserted in the same cycle instead.
- R7: A starvation count rises on each pixel issue while vertex work is pending, saturating at STARVE_LIMIT (default 64). It clears on a vertex issue or when no vertex work is pending. At the limit, eligible vertex work is preferred regardless of bias, so the vertex issue follows exactly 64 consecutive pixel issues.
- R8: Pending counts rise on a push, fall on an issue handshake (valid and ready), and are unchanged when both happen in a cycle. A push to a full queue is dropped, so 20 vertex pushes into a 16-deep queue yield exactly 16 vertex issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bias_we_i | input | 1 | Bias write strobe |
| bias_i | input | 4 | Signed bias value, two's complement |
| vtx_push_i | input | 1 | One vertex group enters the pending queue |
| pix_push_i | input | 1 | One pixel group enters the pending queue |
| ras_push_i | input | 1 | Rasterization adds one entry to the downstream queue |
| ras_pop_i | input | 1 | One entry leaves the downstream queue |
| vtx_valid_o | output | 1 | Vertex group offered to the sequencer |
| vtx_ready_i | input | 1 | Sequencer accepts a vertex group |
| pix_valid_o | output | 1 | Pixel group offered to the sequencer |
| pix_ready_i | input | 1 | Sequencer accepts a pixel group |

## Verification
The properties assume the sequencer's ready inputs do not depend on this block's valid outputs; otherwise the swap rule would form a combinational loop. They also assume pops of the downstream queue are harmless when it is empty. The stimulus drives the ready inputs and the push pulses from the random source on the falling edge, independently of the outputs. It issues `ras_pop_i` only when the bench's own model shows the downstream queue holding entries. Directed phases reach the states that random traffic rarely hits: a full vertex queue under push pressure, a full downstream queue, and a long run of pixel issues against a strong negative bias.

// File: rtl/shq_pkg.sv
package shq_pkg;
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_VTX  = 2'd1,
    PICK_PIX  = 2'd2
  } pick_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/shq_occ_counter.sv
module shq_occ_counter #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;
  logic          full, empty, pop_ok, push_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop_i && !empty;
  assign push_ok = push_i && (!full || pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_ok && !pop_ok) cnt_q <= cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/shq_starve.sv
module shq_starve #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned SW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vtx_wait_i,
  input  logic vtx_fire_i,
  input  logic pix_fire_i,
  output logic force_o
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (vtx_fire_i || !vtx_wait_i)       cnt_q <= '0;
    else if (pix_fire_i && cnt_q != SW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign force_o = (cnt_q == SW'(LIMIT));
endmodule

// File: rtl/shq_policy.sv
module shq_policy
  import shq_pkg::*;
#(
  parameter int unsigned VCW    = 5,
  parameter int unsigned PCW    = 5,
  parameter int unsigned BIAS_W = 4,
  localparam int unsigned DW    = max3(VCW, PCW, BIAS_W) + 2
) (
  input  logic [VCW-1:0]           vcnt_i,
  input  logic [PCW-1:0]           pcnt_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  input  logic                     vtx_elig_i,
  input  logic                     pix_elig_i,
  input  logic                     force_vtx_i,
  input  logic                     vtx_ready_i,
  input  logic                     pix_ready_i,
  output logic                     vtx_valid_o,
  output logic                     pix_valid_o
);
  logic signed [DW-1:0] v_s, p_s, b_s, diff;
  logic  want_vtx, swap_to_pix, swap_to_vtx;
  pick_e prim;

  assign v_s  = signed'(DW'(vcnt_i));
  assign p_s  = signed'(DW'(pcnt_i));
  assign b_s  = DW'(bias_i);
  assign diff = v_s - p_s + b_s;
  assign want_vtx = (diff > 0) || force_vtx_i;

  always_comb begin
    prim = PICK_NONE;
    if (vtx_elig_i && (want_vtx || !pix_elig_i)) prim = PICK_VTX;
    else if (pix_elig_i)                         prim = PICK_PIX;
  end

  // hand an idle slot to the other type when the preferred one stalls
  assign swap_to_pix = (prim == PICK_VTX) && !vtx_ready_i && pix_elig_i && pix_ready_i;
  assign swap_to_vtx = (prim == PICK_PIX) && !pix_ready_i && vtx_elig_i && vtx_ready_i;

  assign vtx_valid_o = ((prim == PICK_VTX) && !swap_to_pix) || swap_to_vtx;
  assign pix_valid_o = ((prim == PICK_PIX) && !swap_to_vtx) || swap_to_pix;
endmodule

// File: rtl/unified_shader_arbiter.sv
module unified_shader_arbiter #(
  parameter int unsigned VTX_DEPTH   = 16,
  parameter int unsigned PIX_DEPTH   = 16,
  parameter int unsigned DS_DEPTH    = 8,
  parameter int unsigned STARVE_LIMIT = 64,
  parameter int unsigned BIAS_W      = 4,
  localparam int unsigned VCW = $clog2(VTX_DEPTH + 1),
  localparam int unsigned PCW = $clog2(PIX_DEPTH + 1),
  localparam int unsigned DCW = $clog2(DS_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bias_we_i,
  input  logic [BIAS_W-1:0] bias_i,
  input  logic              vtx_push_i,
  input  logic              pix_push_i,
  input  logic              ras_push_i,
  input  logic              ras_pop_i,
  output logic              vtx_valid_o,
  input  logic              vtx_ready_i,
  output logic              pix_valid_o,
  input  logic              pix_ready_i
);
  logic signed [BIAS_W-1:0] bias_q;
  logic [VCW-1:0] vcnt;
  logic [PCW-1:0] pcnt;
  logic [DCW-1:0] dcnt;
  logic ds_full, vtx_elig, pix_elig, vtx_fire, pix_fire, force_vtx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bias_q <= '0;
    else if (bias_we_i) bias_q <= signed'(bias_i);
  end

  assign vtx_fire = vtx_valid_o && vtx_ready_i;
  assign pix_fire = pix_valid_o && pix_ready_i;

  shq_occ_counter #(.DEPTH(VTX_DEPTH)) u_vtx_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(vtx_push_i), .pop_i(vtx_fire), .count_o(vcnt));

  shq_occ_counter #(.DEPTH(PIX_DEPTH)) u_pix_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(pix_push_i), .pop_i(pix_fire), .count_o(pcnt));

  shq_occ_counter #(.DEPTH(DS_DEPTH)) u_ds_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(ras_push_i), .pop_i(ras_pop_i), .count_o(dcnt));

  assign ds_full  = (dcnt == DCW'(DS_DEPTH));
  assign vtx_elig = (vcnt != '0) && !ds_full;
  assign pix_elig = (pcnt != '0);

  shq_starve #(.LIMIT(STARVE_LIMIT)) u_starve (
    .clk_i(clk_i), .rst_ni(rst_ni), .vtx_wait_i(vcnt != '0),
    .vtx_fire_i(vtx_fire), .pix_fire_i(pix_fire), .force_o(force_vtx));

  shq_policy #(.VCW(VCW), .PCW(PCW), .BIAS_W(BIAS_W)) u_policy (
    .vcnt_i(vcnt), .pcnt_i(pcnt), .bias_i(bias_q),
    .vtx_elig_i(vtx_elig), .pix_elig_i(pix_elig), .force_vtx_i(force_vtx),
    .vtx_ready_i(vtx_ready_i), .pix_ready_i(pix_ready_i),
    .vtx_valid_o(vtx_valid_o), .pix_valid_o(pix_valid_o));
endmodule

// File: rtl/shq_checker.sv
module shq_checker #(
  parameter int unsigned VCW = 5,
  parameter int unsigned PCW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [VCW-1:0] vcnt,
  input logic [PCW-1:0] pcnt,
  input logic           ds_full,
  input logic           vtx_push_i,
  input logic           pix_push_i,
  input logic           vtx_valid_o,
  input logic           vtx_ready_i,
  input logic           pix_valid_o,
  input logic           pix_ready_i
);
  AST_ONE_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vtx_valid_o, pix_valid_o})); // R2

  AST_NO_VTX_DS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_full |-> !vtx_valid_o); // R4

  AST_PIX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt == '0 && pcnt != '0) |-> pix_valid_o); // R3

  AST_VTX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt == '0 && vcnt != '0 && !ds_full) |-> vtx_valid_o); // R3

  AST_SWAP_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt != '0 && pix_ready_i && !vtx_ready_i) |-> pix_valid_o); // R6

  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt == '0 && pcnt == '0) |-> !(vtx_valid_o || pix_valid_o)); // R8

  AST_VCNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vtx_push_i && !(vtx_valid_o && vtx_ready_i)) |=> $stable(vcnt)); // R8

  AST_PCNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_push_i == (pix_valid_o && pix_ready_i)) && pcnt != '0 && pcnt != '1 |=> $stable(pcnt)); // R8
endmodule

bind unified_shader_arbiter shq_checker #(.VCW(VCW), .PCW(PCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vcnt(vcnt), .pcnt(pcnt), .ds_full(ds_full),
  .vtx_push_i(vtx_push_i), .pix_push_i(pix_push_i),
  .vtx_valid_o(vtx_valid_o), .vtx_ready_i(vtx_ready_i),
  .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i));

// File: tb/unified_shader_arbiter_tb.sv
module unified_shader_arbiter_tb_top;
  localparam int VD = 16, PD = 16, DD = 8, LIM = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_we = 0, vtx_push = 0, pix_push = 0, ras_push = 0, ras_pop = 0;
  logic vtx_ready = 0, pix_ready = 0;
  logic [3:0] bias_v = '0;
  logic vtx_valid, pix_valid;

  int n_chk = 0, n_fail = 0;
  int mv = 0, mp = 0, md = 0, mb = 0, ms = 0;
  int vfires = 0, pfires = 0;
  bit done = 0;

  always #5 clk = ~clk;

  unified_shader_arbiter #(.VTX_DEPTH(VD), .PIX_DEPTH(PD), .DS_DEPTH(DD),
                           .STARVE_LIMIT(LIM), .BIAS_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bias_we_i(bias_we), .bias_i(bias_v),
    .vtx_push_i(vtx_push), .pix_push_i(pix_push),
    .ras_push_i(ras_push), .ras_pop_i(ras_pop),
    .vtx_valid_o(vtx_valid), .vtx_ready_i(vtx_ready),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected outputs from the requirements
  task automatic expect_out(output bit ev, output bit ep, output string tag);
    bit ve, pe, want, pv, pp, sp, sv;
    ve = (mv != 0) && (md < DD);
    pe = (mp != 0);
    want = (mv - mp + mb > 0) || (ms == LIM);
    pv = ve && (want || !pe);
    pp = pe && !pv;
    sp = pv && !vtx_ready && pe && pix_ready;
    sv = pp && !pix_ready && ve && vtx_ready;
    ev = (pv && !sp) || sv;
    ep = (pp && !sv) || sp;
    if (mv != 0 && md >= DD) tag = "R4";
    else if (sp || sv)       tag = "R6";
    else if (ms == LIM && ve) tag = "R7";
    else if (!ve || !pe)     tag = "R3";
    else if (mb != 0)        tag = "R5";
    else                     tag = "R2";
  endtask

  // called at negedge with inputs set; compares, then advances the model
  task automatic step();
    bit ev, ep, vf, pf, vok, pok, dpop, dok;
    string tag;
    #1;
    expect_out(ev, ep, tag);
    chk(vtx_valid === ev, tag, vtx_valid, ev);
    chk(pix_valid === ep, tag, pix_valid, ep);
    vf = vtx_valid && vtx_ready;
    pf = pix_valid && pix_ready;
    vfires += vf; pfires += pf;
    @(posedge clk);
    vok = vtx_push && (mv < VD || vf);
    pok = pix_push && (mp < PD || pf);
    dpop = ras_pop && md > 0;
    dok = ras_push && (md < DD || dpop);
    if (vf || mv == 0) ms = 0;
    else if (pf && ms < LIM) ms++;
    mv += int'(vok) - int'(vf);
    mp += int'(pok) - int'(pf);
    md += int'(dok) - int'(dpop);
    if (bias_we) mb = (bias_v[3]) ? int'(bias_v) - 16 : int'(bias_v);
    @(negedge clk);
  endtask

  task automatic idle_in();
    bias_we = 0; vtx_push = 0; pix_push = 0; ras_push = 0; ras_pop = 0;
  endtask

  task automatic do_reset();
    idle_in(); vtx_ready = 0; pix_ready = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    mv = 0; mp = 0; md = 0; mb = 0; ms = 0;
    #1;
    chk(!vtx_valid && !pix_valid, "R1", {vtx_valid, pix_valid}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic rand_phase(input int cycles, input int pv, input int pp,
                            input int pr, input int prd, input bit bias_on);
    for (int i = 0; i < cycles; i++) begin
      idle_in();
      vtx_push = ($urandom % 100) < pv;
      pix_push = ($urandom % 100) < pp;
      ras_push = ($urandom % 100) < pr;
      ras_pop  = (md > 0) && (($urandom % 100) < prd);
      vtx_ready = ($urandom % 100) < 70;
      pix_ready = ($urandom % 100) < 70;
      if (bias_on && ($urandom % 50) == 0) begin
        bias_we = 1; bias_v = 4'($urandom);
      end
      step();
    end
  endtask

  initial begin
    int pix_before;
    bit seen;
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // R1 bias zero after reset, R2 tie goes to pixels
    vtx_push = 1; pix_push = 1; step();
    idle_in(); vtx_ready = 1; pix_ready = 1; #1;
    chk(pix_valid && !vtx_valid, "R2", {vtx_valid, pix_valid}, 1);
    vtx_ready = 0; pix_ready = 0; step();
    // R5 bias +1 flips preference to vertex
    bias_we = 1; bias_v = 4'd1; step();
    idle_in(); vtx_ready = 1; pix_ready = 1; #1;
    chk(vtx_valid && !pix_valid, "R5", {vtx_valid, pix_valid}, 2);
    // R6 preferred vertex stalled, pixel takes slot
    vtx_ready = 0; #1;
    chk(pix_valid && !vtx_valid, "R6", {vtx_valid, pix_valid}, 1);
    vtx_ready = 0; pix_ready = 0; step();

    // R8 push saturation: 20 vertex pushes into 16-deep queue
    do_reset();
    for (int i = 0; i < 20; i++) begin vtx_push = 1; step(); end
    idle_in(); vtx_ready = 1;
    vfires = 0;
    for (int i = 0; i < 24; i++) step();
    chk(vfires == 16, "R8", vfires, 16);

    // R4 downstream full blocks vertex
    do_reset();
    for (int i = 0; i < DD; i++) begin ras_push = 1; step(); end
    idle_in(); vtx_push = 1; step();
    idle_in(); vtx_ready = 1; #1;
    chk(!vtx_valid, "R4", vtx_valid, 0);
    ras_pop = 1; step();
    idle_in(); #1;
    chk(vtx_valid, "R4", vtx_valid, 1);
    step();

    // R7 starvation under strong negative bias
    do_reset();
    bias_we = 1; bias_v = 4'b1000; step();
    idle_in();
    for (int i = 0; i < 10; i++) begin pix_push = 1; step(); end
    idle_in(); vtx_push = 1; step();
    idle_in(); vtx_ready = 1; pix_ready = 1; pix_push = 1;
    pfires = 0; seen = 0; pix_before = 0;
    for (int i = 0; i < 80 && !seen; i++) begin
      #1;
      if (vtx_valid) begin seen = 1; pix_before = pfires; end
      #0 step();
    end
    chk(seen && pix_before == LIM, "R7", pix_before, LIM);

    // random mixes
    do_reset();
    rand_phase(3000, 40, 45, 30, 35, 1);
    rand_phase(3000, 60, 20, 60, 20, 1);
    rand_phase(3000, 10, 70, 10, 60, 1);
    rand_phase(3000, 50, 50, 45, 45, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule